// File: doc/BRIEF.md
# Multi-Format Audio Serial Port

This block is a slave-side serial audio port. An external bit clock and word clock define the framing. One serial input carries received audio words and one serial output carries transmitted words, both most significant bit first. A single framing engine covers five formats. Two use a square-wave word clock with left and right halves: I2S and left-justified. Right-justified also uses a square wave. DSP and mono PCM use a one-bit-clock frame pulse. The word length is selectable, and the first data bit can be delayed by 0 to 255 bit clocks from the frame edge.

All three serial pins are brought into the system clock through two-flop synchronizers, and bit-clock edges are detected there. The bit clock must therefore run well below the system clock, at no more than one eighth of it. On the host side the block presents received left and right samples with a one-cycle strobe. It takes transmit samples from two parallel inputs at each frame start and pulses a strobe when it does so. Samples are right-aligned in 32-bit words.

Configuration arrives on static input ports and is captured only at a frame start. When tri-state is selected, the output enable is dropped outside data bits so that the pin can be shared.

Top module: `aud_serial_port`

## Requirements
- R1: `cfg_mode` selects the framing: 0 = I2S, 1 = DSP, 2 = right-justified, 3 = left-justified, 4 = mono PCM. After reset the latched framing is I2S, with 24-bit words, offset 0 and tri-state off.
- R2: `cfg_len` selects the word size N: 0 = 16, 1 = 20, 2 = 24, 3 = 32. Words move MSB first. Parallel samples use bits N-1..0, and unused received bits read as 0.
- R3: In I2S mode the left half is word clock low and the right half is high. Each word's MSB sits on the second bit clock of its half, plus the offset.
- R4: In left-justified mode the left half is word clock high. Each word's MSB sits on the first bit clock of its half, plus the offset.
- R5: In right-justified mode (left half high), the MSB position equals the previous half's bit-clock count minus N, or 0 if that is negative, plus the offset. With offset 0 the LSB lands on the last bit clock of the half.
- R6: In DSP mode a frame begins at the bit clock where the word clock is first seen high. The left word starts at the offset, and the right word follows it with no gap.
- R7: In mono PCM mode the frame is pulse-framed with one word at the offset. The received word is written to both `rx_left` and `rx_right`, and `tx_left` supplies the transmitted word.
- R8: `cfg_offset` (0 to 255) delays the first data bit by that many bit clocks, on top of the delay the format itself imposes.
- R9: On bit clocks that carry no data bit, `sdout` is 0. `sdout_oe` is 0 if tri-state was latched and 1 otherwise. On data bits `sdout_oe` is 1.
- R10: `sdout` changes only after a bit-clock falling edge. `sdin` is taken at bit-clock rising edges.
- R11: The configuration inputs and `tx_left`/`tx_right` are captured only at a frame start. A change made mid-frame affects only later frames.
- R12: `rx_valid` pulses for one system clock once per frame, after the last received word. `rx_left` and `rx_right` change only together with that pulse.
- R13: During reset `sdout` is 0, `sdout_oe` is 1, `rx_valid` is 0 and the received samples are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock from the bus |
| wclk | input | 1 | Word clock / frame sync from the bus |
| sdin | input | 1 | Serial receive data |
| cfg_mode | input | 3 | Framing select |
| cfg_len | input | 2 | Word length select |
| cfg_offset | input | 8 | Data start delay in bit clocks |
| cfg_tristate | input | 1 | Release output enable outside data bits |
| tx_left | input | 32 | Left (or mono) transmit sample |
| tx_right | input | 32 | Right transmit sample |
| sdout | output | 1 | Serial transmit data |
| sdout_oe | output | 1 | Output enable for sdout |
| rx_left | output | 32 | Received left sample |
| rx_right | output | 32 | Received right sample |
| rx_valid | output | 1 | One-cycle strobe: new received pair |
| tx_taken | output | 1 | One-cycle strobe: transmit samples captured |

## Verification
Two things can land on the same bit clock: the capture of a new configuration and transmit pair at a frame start, and the decision to drive the first data bit. This happens in left-justified and zero-offset pulse modes, where the MSB must go out on the very falling edge that opens the frame. The vector table runs such cases and compares every driven bit, and every enable level, with an independently computed slot map. A second collision is forced on purpose: the word length is changed while a word is being received. The checks require that word to keep its old length and the next frame to use the new one.

// File: rtl/aud_serial_port.sv
module aud_serial_port #(
  parameter int DW    = 32,
  parameter int POS_W = 9,
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk,
  input  logic             wclk,
  input  logic             sdin,
  input  logic [2:0]       cfg_mode,
  input  logic [1:0]       cfg_len,
  input  logic [OFF_W-1:0] cfg_offset,
  input  logic             cfg_tristate,
  input  logic [DW-1:0]    tx_left,
  input  logic [DW-1:0]    tx_right,
  output logic             sdout,
  output logic             sdout_oe,
  output logic [DW-1:0]    rx_left,
  output logic [DW-1:0]    rx_right,
  output logic             rx_valid,
  output logic             tx_taken
);

  localparam int SW = POS_W + 1;
  localparam int IW = $clog2(DW);
  localparam logic [2:0] M_I2S = 3'd0;
  localparam logic [2:0] M_DSP = 3'd1;
  localparam logic [2:0] M_RJ  = 3'd2;
  localparam logic [2:0] M_LJ  = 3'd3;
  localparam logic [2:0] M_PCM = 3'd4;
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [2:0] bclk_s;
  logic [1:0] wclk_s, sdin_s;
  logic       bclk_rise, bclk_fall, w, sd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_s <= '0;
      wclk_s <= '0;
      sdin_s <= '0;
    end else begin
      bclk_s <= {bclk_s[1:0], bclk};
      wclk_s <= {wclk_s[0], wclk};
      sdin_s <= {sdin_s[0], sdin};
    end
  end

  assign bclk_rise = bclk_s[1] & ~bclk_s[2];
  assign bclk_fall = ~bclk_s[1] & bclk_s[2];
  assign w         = wclk_s[1];
  assign sd        = sdin_s[1];

  logic [2:0]       mode_q;
  logic [1:0]       len_q;
  logic [OFF_W-1:0] off_q;
  logic             ts_q;
  logic [DW-1:0]    txl_q, txr_q;
  logic             w_prev;
  logic [POS_W-1:0] pos;
  logic [SW-1:0]    hlen;

  logic             square_q, edge_sq, edge_pl, bnd, fstart;
  logic [2:0]       m;
  logic [1:0]       ln;
  logic [OFF_W-1:0] off;
  logic             ts;
  logic [DW-1:0]    txl, txr;
  logic [POS_W-1:0] npos;
  logic [SW-1:0]    hl_eff, nb, base, start, rel, rel_w, span;
  logic             in_rng, act, second, chan, tx_bit;
  logic [IW-1:0]    idx;

  assign square_q = (mode_q == M_I2S) | (mode_q == M_RJ) | (mode_q == M_LJ);
  assign edge_sq  = w ^ w_prev;
  assign edge_pl  = w & ~w_prev;
  assign bnd      = square_q ? edge_sq : edge_pl;
  assign fstart   = square_q ? (edge_sq & (w == (mode_q != M_I2S))) : edge_pl;

  assign m   = fstart ? cfg_mode     : mode_q;
  assign ln  = fstart ? cfg_len      : len_q;
  assign off = fstart ? cfg_offset   : off_q;
  assign ts  = fstart ? cfg_tristate : ts_q;
  assign txl = fstart ? tx_left      : txl_q;
  assign txr = fstart ? tx_right     : txr_q;

  assign npos   = bnd ? '0 : ((pos == POS_MAX) ? pos : pos + 1'b1);
  assign hl_eff = bnd ? ({1'b0, pos} + SW'(1)) : hlen;

  always_comb begin
    case (ln)
      2'd0:    nb = SW'(16);
      2'd1:    nb = SW'(20);
      2'd2:    nb = SW'(24);
      default: nb = SW'(32);
    endcase
    case (m)
      M_I2S:   base = SW'(1);
      M_RJ:    base = (hl_eff > nb) ? hl_eff - nb : '0;
      default: base = '0;
    endcase
  end

  assign start  = base + SW'(off);
  assign in_rng = {1'b0, npos} >= start;
  assign rel    = {1'b0, npos} - start;
  assign span   = (m == M_DSP) ? (nb << 1) : nb;
  assign act    = in_rng && (rel < span);
  assign second = (m == M_DSP) && (rel >= nb);
  assign rel_w  = second ? rel - nb : rel;
  assign chan   = (m == M_I2S) ? w : ((m == M_RJ) | (m == M_LJ)) ? ~w : second;
  assign idx    = IW'(nb - SW'(1) - rel_w);
  assign tx_bit = chan ? txr[idx] : txl[idx];

  logic          act_q, chan_q, first_q, last_q, mono_q;
  logic [DW-1:0] sh, lhold, word;

  assign word = {sh[DW-2:0], sd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_I2S;
      len_q    <= 2'd2;
      off_q    <= '0;
      ts_q     <= 1'b0;
      txl_q    <= '0;
      txr_q    <= '0;
      w_prev   <= 1'b0;
      pos      <= POS_MAX;
      hlen     <= '0;
      act_q    <= 1'b0;
      chan_q   <= 1'b0;
      first_q  <= 1'b0;
      last_q   <= 1'b0;
      mono_q   <= 1'b0;
      sdout    <= 1'b0;
      sdout_oe <= 1'b1;
      tx_taken <= 1'b0;
      sh       <= '0;
      lhold    <= '0;
      rx_left  <= '0;
      rx_right <= '0;
      rx_valid <= 1'b0;
    end else begin
      tx_taken <= 1'b0;
      rx_valid <= 1'b0;
      if (bclk_fall) begin
        w_prev <= w;
        pos    <= npos;
        if (bnd) hlen <= hl_eff;
        if (fstart) begin
          mode_q   <= cfg_mode;
          len_q    <= cfg_len;
          off_q    <= cfg_offset;
          ts_q     <= cfg_tristate;
          txl_q    <= tx_left;
          txr_q    <= tx_right;
          tx_taken <= 1'b1;
        end
        act_q    <= act;
        chan_q   <= chan;
        first_q  <= (rel_w == '0);
        last_q   <= (idx == '0);
        mono_q   <= (m == M_PCM);
        sdout    <= act & tx_bit;
        sdout_oe <= act | ~ts;
      end
      if (bclk_rise && act_q) begin
        sh <= first_q ? {{(DW-1){1'b0}}, sd} : word;
        if (last_q) begin
          if (mono_q) begin
            rx_left  <= word;
            rx_right <= word;
            rx_valid <= 1'b1;
          end else if (!chan_q) begin
            lhold <= word;
          end else begin
            rx_left  <= lhold;
            rx_right <= word;
            rx_valid <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/aud_serial_port_chk.sv
module aud_serial_port_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bclk_fall,
  input logic          sdout,
  input logic          sdout_oe,
  input logic          rx_valid,
  input logic [DW-1:0] rx_left,
  input logic [DW-1:0] rx_right,
  input logic          mono_q,
  input logic          tx_taken
);

  p_sdout_after_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout) |-> $past(bclk_fall));

  p_oe_after_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout_oe) |-> $past(bclk_fall));

  p_valid_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_left_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_left) |-> rx_valid);

  p_right_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_right) |-> rx_valid);

  p_mono_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && mono_q) |-> (rx_left == rx_right));

  p_capture_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_taken |=> !tx_taken);

endmodule

bind aud_serial_port aud_serial_port_chk #(.DW(DW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bclk_fall (bclk_fall),
  .sdout     (sdout),
  .sdout_oe  (sdout_oe),
  .rx_valid  (rx_valid),
  .rx_left   (rx_left),
  .rx_right  (rx_right),
  .mono_q    (mono_q),
  .tx_taken  (tx_taken)
);

// File: tb/aud_serial_port_tb.sv
module aud_serial_port_tb_top;

  logic        clk = 1'b0, rst_n = 1'b0, bclk = 1'b1, wclk = 1'b0, sdin = 1'b0;
  logic [2:0]  cfg_mode = 3'd0;
  logic [1:0]  cfg_len = 2'd2;
  logic [7:0]  cfg_offset = 8'd0;
  logic        cfg_tristate = 1'b0;
  logic [31:0] tx_left = '0, tx_right = '0;
  logic        sdout, sdout_oe, rx_valid, tx_taken;
  logic [31:0] rx_left, rx_right;

  always #4 clk = ~clk;

  aud_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .wclk(wclk), .sdin(sdin),
    .cfg_mode(cfg_mode), .cfg_len(cfg_len), .cfg_offset(cfg_offset),
    .cfg_tristate(cfg_tristate), .tx_left(tx_left), .tx_right(tx_right),
    .sdout(sdout), .sdout_oe(sdout_oe), .rx_left(rx_left), .rx_right(rx_right),
    .rx_valid(rx_valid), .tx_taken(tx_taken)
  );

  typedef struct packed {
    logic [2:0]  md;
    logic [1:0]  ln;
    logic [7:0]  off;
    logic        ts;
    logic [9:0]  hl;
    logic [31:0] dl;
    logic [31:0] dr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd2, 8'd0,   1'b0, 10'd32,  32'h00C3_5A17, 32'h0089_ABCD},
    '{3'd0, 2'd0, 8'd2,   1'b1, 10'd32,  32'h0000_B00F, 32'h0000_4E21},
    '{3'd3, 2'd3, 8'd0,   1'b0, 10'd32,  32'hDEAD_BEEF, 32'h1357_9BDF},
    '{3'd3, 2'd1, 8'd3,   1'b1, 10'd24,  32'h000A_5F0C, 32'h0005_30E9},
    '{3'd2, 2'd0, 8'd0,   1'b1, 10'd32,  32'h0000_9C3A, 32'h0000_61F5},
    '{3'd2, 2'd2, 8'd0,   1'b0, 10'd32,  32'h00F0_0F55, 32'h002B_7D91},
    '{3'd1, 2'd0, 8'd0,   1'b1, 10'd40,  32'h0000_8001, 32'h0000_7FFE},
    '{3'd1, 2'd2, 8'd1,   1'b0, 10'd64,  32'h0096_3C5A, 32'h0069_C3A5},
    '{3'd4, 2'd1, 8'd0,   1'b1, 10'd32,  32'h000C_AFE5, 32'h0000_0000},
    '{3'd4, 2'd3, 8'd5,   1'b0, 10'd48,  32'h8765_4321, 32'h0000_0000},
    '{3'd1, 2'd0, 8'd255, 1'b1, 10'd300, 32'h0000_A5A5, 32'h0000_3C3C},
    '{3'd0, 2'd3, 8'd0,   1'b1, 10'd33,  32'hF00D_CAFE, 32'h0BAD_F00D}
  };

  int errs = 0, checks = 0, vcount = 0;
  bit done = 1'b0;
  logic [31:0] cap_l = '0, cap_r = '0;

  always @(negedge clk) if (rx_valid === 1'b1) begin
    vcount++;
    cap_l = rx_left;
    cap_r = rx_right;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbits(input logic [1:0] ln);
    return (ln == 2'd0) ? 16 : (ln == 2'd1) ? 20 : (ln == 2'd2) ? 24 : 32;
  endfunction

  function automatic string mtag(input logic [2:0] md);
    case (md)
      3'd0: return "R3 R1";
      3'd1: return "R6 R1";
      3'd2: return "R5 R1";
      3'd3: return "R4 R1";
      default: return "R7 R1";
    endcase
  endfunction

  task automatic slot(input logic [2:0] md, input logic [1:0] ln, input int off, input int hl,
                      input int h, input int p, output bit a, output bit c, output int ix);
    int nb, st, rel, span;
    nb = nbits(ln);
    case (md)
      3'd0: st = 1 + off;
      3'd2: st = ((hl > nb) ? hl - nb : 0) + off;
      default: st = off;
    endcase
    rel  = p - st;
    span = (md == 3'd1) ? 2 * nb : nb;
    a    = (p >= st) && (rel < span);
    c    = (md == 3'd0 || md == 3'd2 || md == 3'd3) ? h[0] : 1'b0;
    if (md == 3'd1 && rel >= nb) begin
      c   = 1'b1;
      rel = rel - nb;
    end
    ix = a ? nb - 1 - rel : 0;
  endtask

  task automatic run_frame(input vec_t v, input bit chk, input int swap_p, input logic [1:0] swap_len);
    int terr = 0, oerr = 0, nh;
    bit sq, a, c, eo;
    int ix;
    logic [31:0] tl, tr;
    tl = v.dl ^ 32'hA5C3_0F96;
    tr = v.dr ^ 32'h3C69_F00F;
    tx_left  = tl;
    tx_right = tr;
    sq = (v.md == 3'd0) || (v.md == 3'd2) || (v.md == 3'd3);
    nh = sq ? 2 : 1;
    for (int h = 0; h < nh; h++) begin
      for (int p = 0; p < int'(v.hl); p++) begin
        slot(v.md, v.ln, int'(v.off), int'(v.hl), h, p, a, c, ix);
        bclk = 1'b0;
        wclk = sq ? ((v.md == 3'd0) ? (h == 1) : (h == 0)) : (p == 0);
        sdin = a ? (c ? v.dr[ix] : v.dl[ix]) : 1'b0;
        if (h == 0 && p == swap_p) cfg_len = swap_len;
        #32;
        if (chk) begin
          eo = a | ~v.ts;
          if (sdout_oe !== eo) oerr++;
          else if (sdout_oe && (sdout !== (a ? (c ? tr[ix] : tl[ix]) : 1'b0))) terr++;
        end
        #32 bclk = 1'b1;
        #64;
      end
    end
    if (chk) begin
      check(terr == 0, {mtag(v.md), " R2 R8 R10 sdout bit errors"}, terr, 0);
      check(oerr == 0, {mtag(v.md), " R9 sdout_oe errors"}, oerr, 0);
    end
  endtask

  task automatic check_rx(input vec_t v, input string what);
    logic [31:0] mask, el, er;
    mask = (nbits(v.ln) == 32) ? 32'hFFFF_FFFF : ((32'd1 << nbits(v.ln)) - 32'd1);
    el = v.dl & mask;
    er = (v.md == 3'd4) ? el : (v.dr & mask);
    check(cap_l === el, {mtag(v.md), " R2 ", what, " rx_left"}, cap_l, el);
    check(cap_r === er, {mtag(v.md), " R2 R7 ", what, " rx_right"}, cap_r, er);
  endtask

  task automatic apply_cfg(input vec_t v);
    cfg_mode     = v.md;
    cfg_len      = v.ln;
    cfg_offset   = v.off;
    cfg_tristate = v.ts;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    vec_t v, v16;
    #3;
    #80;
    // R13 reset state
    check(sdout === 1'b0,    "R13 sdout in reset",    sdout, 0);
    check(sdout_oe === 1'b1, "R13 sdout_oe in reset", sdout_oe, 1);
    check(rx_valid === 1'b0, "R13 rx_valid in reset", rx_valid, 0);
    check(rx_left === 32'h0, "R13 rx_left in reset",  rx_left, 0);
    rst_n = 1'b1;
    #80;
    check(sdout_oe === 1'b1 && sdout === 1'b0, "R13 idle output after reset", {sdout_oe, sdout}, 32'h2);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      apply_cfg(v);
      run_frame(v, 1'b0, -1, 2'd0);
      vcount = 0;
      run_frame(v, 1'b0, -1, 2'd0);
      run_frame(v, 1'b1, -1, 2'd0);
      check_rx(v, "vector");
      check(vcount == 2, "R12 one rx_valid per frame", vcount, 2);
    end

    // R11: length change in the middle of a frame waits for the next frame start
    v = '{3'd0, 2'd2, 8'd1, 1'b1, 10'd32, 32'h00AB_CDEF, 32'h0012_3456};
    apply_cfg(v);
    run_frame(v, 1'b0, -1, 2'd0);
    run_frame(v, 1'b0, -1, 2'd0);
    run_frame(v, 1'b1, 4, 2'd0);
    check_rx(v, "R11 old length kept mid-frame");
    v16 = v;
    v16.ln = 2'd0;
    run_frame(v16, 1'b1, -1, 2'd0);
    check_rx(v16, "R11 new length next frame");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(190000 * 8);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule